// File: doc/BRIEF.md
# Watchdog Timer with Keyed Two-Write Feed

This block is a down-counting watchdog. Once out of reset it counts down a selectable period of watchdog ticks, and at the end of the period it emits a one-cycle system reset request. Software keeps it from expiring by feeding it. A feed is two byte writes in strict order on a small write port: a first key byte to one feed address, then a second key byte to a different feed address. Any other write that lands between the two, a wrong key, or a wrong order throws the partial sequence away, and the count is not reloaded.

The watchdog tick comes from one of two sources. One is a free-running low-speed oscillator tick (`osc_tick`). The other is the peripheral clock, where every `clk` cycle is a tick. When the peripheral clock is the source and the chip signals power-down, counting stops and the count is held. A sticky timeout flag records that an expiry happened. It is cleared only by this block's own reset input, so it survives the system reset that the expiry triggers.

Top module: `wdog_feed_guard`

## Requirements
- R1: While reset is asserted and after it is released, `wdt_rst` is 0 and `tmo_flag` is 0 until the first expiry.
- R2: A write of 0xA5 to address 1, followed by a write of 0x5A to address 2 with no other write between them, is a valid feed. It is accepted at the edge that captures the second write. The count is reloaded at the next edge, and `wdt_rst` then rises after a full period of ticks counted from that reload edge.
- R3: A write to any address (including address 1 with a value other than 0xA5) that falls between the two feed writes discards the sequence, and the count is not reloaded.
- R4: A feed write with a wrong byte (not 0xA5 first, or not 0x5A second) or a sequence with the two addresses swapped does not reload the count.
- R5: The period is 2^(`tmo_sel`+5) ticks, taking the value of `tmo_sel` at the moment of reload.
- R6: `wdt_rst` is high for exactly one clock cycle per expiry. The count then restarts by itself, and the next expiry follows one full period later.
- R7: `tmo_flag` is set at the first expiry and stays set through later feeds and expiries until `rst_n` is asserted.
- R8: With `src_sel`=0 only cycles with `osc_tick`=1 count as ticks. With `src_sel`=1 every clock cycle is a tick.
- R9: With `src_sel`=1 and `pwr_down`=1 the count is held, so the expiry is delayed by exactly the held cycles. With `src_sel`=0, `pwr_down` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the peripheral-clock tick source |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the shared register bus |
| wr_addr | input | 2 | Write address; 1 and 2 are the feed registers, others are other registers |
| wr_data | input | 8 | Write data byte |
| tmo_sel | input | 3 | Period select N, period 2^(N+5) ticks |
| src_sel | input | 1 | Tick source: 0 oscillator tick, 1 peripheral clock |
| osc_tick | input | 1 | One-cycle tick pulses from the low-speed oscillator domain |
| pwr_down | input | 1 | Power-down indication from the system |
| wdt_rst | output | 1 | One-cycle reset request on expiry |
| tmo_flag | output | 1 | Sticky flag, set by any expiry |

## Verification
A count or reload error moves the edge at which `wdt_rst` rises. The bench therefore predicts that edge from the last valid feed and the ticks it drove, and checks that there is no pulse before it and a pulse exactly on it. The error shows within one period, at most 4096 ticks. A feed-sequence state that stays armed or arms wrongly makes a broken sequence reload the count. That moves the expiry by the offset between the two writes, which is visible on the very next expiry. A flag that fails to stick shows one cycle after the pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int SEL_W    = 3;
  localparam int SEL_BASE = 5;
  localparam int CNT_W    = SEL_BASE + (1 << SEL_W);
  localparam int DATA_W   = 8;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hA5;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'h5A;

  typedef enum logic {
    SRC_OSC  = 1'b0,
    SRC_PCLK = 1'b1
  } wd_src_e;

  function automatic logic [CNT_W-1:0] period_of(input logic [SEL_W-1:0] sel);
    logic [CNT_W-1:0] one;
    one = CNT_W'(1);
    return one << (SEL_BASE + int'(sel));
  endfunction
endpackage

// File: rtl/wdog_feed_seq.sv
module wdog_feed_seq
  import wdog_pkg::*;
#(
  parameter int              AW         = 2,
  parameter logic [AW-1:0]   ADDR_FIRST = 2'd1,
  parameter logic [AW-1:0]   ADDR_SECOND = 2'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              feed_ok
);
  logic armed_q, armed_d;
  logic feed_q, feed_d;
  logic hit_first, hit_second;

  assign hit_first  = (wr_addr == ADDR_FIRST)  && (wr_data == KEY_FIRST);
  assign hit_second = (wr_addr == ADDR_SECOND) && (wr_data == KEY_SECOND);

  always_comb begin
    armed_d = armed_q;
    feed_d  = 1'b0;
    if (wr_en) begin
      if (hit_first) begin
        armed_d = 1'b1;
      end else begin
        armed_d = 1'b0;
        feed_d  = armed_q && hit_second;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      feed_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      feed_q  <= feed_d;
    end
  end

  assign feed_ok = feed_q;

  // R2
  feed_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feed_q |=> !feed_q);

  // R4
  arm_from_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(wr_en && wr_addr == ADDR_FIRST && wr_data == KEY_FIRST));

  // R3
  other_write_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(wr_addr == ADDR_FIRST && wr_data == KEY_FIRST)) |=> !armed_q);
endmodule

// File: rtl/wdog_tick_gate.sv
module wdog_tick_gate
  import wdog_pkg::*;
(
  input  logic src_sel,
  input  logic osc_tick,
  input  logic pwr_down,
  output logic cnt_en
);
  wd_src_e src;

  always_comb begin
    src = wd_src_e'(src_sel);
    unique case (src)
      SRC_PCLK: cnt_en = !pwr_down;
      default:  cnt_en = osc_tick;
    endcase
  end
endmodule

// File: rtl/wdog_down_cnt.sv
module wdog_down_cnt
  import wdog_pkg::*;
#(
  parameter logic [SEL_W-1:0] INIT_SEL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             load,
  input  logic [SEL_W-1:0] sel,
  output logic             expire,
  output logic             flag
);
  logic [CNT_W-1:0] cnt_q, cnt_d, reload;
  logic             exp_q, exp_d;
  logic             flag_q, flag_d;

  assign reload = period_of(sel);

  always_comb begin
    cnt_d  = cnt_q;
    exp_d  = 1'b0;
    flag_d = flag_q;
    if (load) begin
      cnt_d = reload;
    end else if (cnt_en) begin
      if (cnt_q == CNT_W'(1)) begin
        cnt_d  = reload;
        exp_d  = 1'b1;
        flag_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= period_of(INIT_SEL);
      exp_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      exp_q  <= exp_d;
      flag_q <= flag_d;
    end
  end

  assign expire = exp_q;
  assign flag   = flag_q;

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |=> !exp_q);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q);

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !load) |=> $stable(cnt_q));

  // R5
  reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(reload)));

  // R6
  never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);
endmodule

// File: rtl/wdog_feed_guard.sv
module wdog_feed_guard
  import wdog_pkg::*;
#(
  parameter int               AW          = 2,
  parameter logic [AW-1:0]    ADDR_FIRST  = 2'd1,
  parameter logic [AW-1:0]    ADDR_SECOND = 2'd2,
  parameter logic [SEL_W-1:0] INIT_SEL    = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  tmo_sel,
  input  logic              src_sel,
  input  logic              osc_tick,
  input  logic              pwr_down,
  output logic              wdt_rst,
  output logic              tmo_flag
);
  logic sync1_q, sync2_q;
  logic rst_n_i;
  logic feed_ok;
  logic cnt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end
  assign rst_n_i = sync2_q;

  wdog_feed_seq #(
    .AW          (AW),
    .ADDR_FIRST  (ADDR_FIRST),
    .ADDR_SECOND (ADDR_SECOND)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .feed_ok (feed_ok)
  );

  wdog_tick_gate u_gate (
    .src_sel  (src_sel),
    .osc_tick (osc_tick),
    .pwr_down (pwr_down),
    .cnt_en   (cnt_en)
  );

  wdog_down_cnt #(
    .INIT_SEL (INIT_SEL)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .cnt_en (cnt_en),
    .load   (feed_ok),
    .sel    (tmo_sel),
    .expire (wdt_rst),
    .flag   (tmo_flag)
  );

  // R1
  quiet_in_reset_chk: assert property (@(posedge clk)
    !rst_n_i |-> (!wdt_rst && !tmo_flag));

  // R6
  flag_follows_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    wdt_rst |-> tmo_flag);
endmodule

// File: tb/wdog_feed_guard_tb.sv
`timescale 1ns/1ps
module wdog_feed_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] tmo_sel;
  logic       src_sel;
  logic       osc_tick;
  logic       pwr_down;
  logic       wdt_rst;
  logic       tmo_flag;

  int checks = 0;
  int errors = 0;
  int edge_no = 0;
  int last_wr = 0;
  int tick_div = 0;
  bit last_en = 1'b0;

  always #5 clk = ~clk;

  wdog_feed_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tmo_sel(tmo_sel), .src_sel(src_sel),
    .osc_tick(osc_tick), .pwr_down(pwr_down), .wdt_rst(wdt_rst),
    .tmo_flag(tmo_flag)
  );

  typedef struct packed {
    logic [2:0] sel;
    logic [1:0] a1;
    logic [7:0] d1;
    logic       mid;
    logic [1:0] ma;
    logic [1:0] a2;
    logic [7:0] d2;
    logic       feed;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd1, 8'hA5, 1'b0, 2'd0, 2'd2, 8'h5A, 1'b1},  // R2 valid
    '{3'd1, 2'd1, 8'hA5, 1'b1, 2'd0, 2'd2, 8'h5A, 1'b0},  // R3 write to addr 0 between
    '{3'd0, 2'd1, 8'hA4, 1'b0, 2'd0, 2'd2, 8'h5A, 1'b0},  // R4 bad first key
    '{3'd2, 2'd1, 8'hA5, 1'b0, 2'd0, 2'd2, 8'h5B, 1'b0},  // R4 bad second key
    '{3'd1, 2'd2, 8'hA5, 1'b0, 2'd0, 2'd1, 8'h5A, 1'b0},  // R4 swapped addresses
    '{3'd2, 2'd1, 8'hA5, 1'b1, 2'd1, 2'd2, 8'h5A, 1'b0},  // R3 other value to addr 1
    '{3'd1, 2'd1, 8'hA5, 1'b0, 2'd0, 2'd2, 8'h5A, 1'b1},  // R5 period 64
    '{3'd2, 2'd1, 8'hA5, 1'b1, 2'd3, 2'd2, 8'h5A, 1'b0},  // R3 write to addr 3 between
    '{3'd3, 2'd1, 8'hA5, 1'b0, 2'd0, 2'd2, 8'h5A, 1'b1}   // R5 period 256
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    osc_tick = (tick_div != 0) && (((edge_no + 1) % tick_div) == 0);
    last_en  = src_sel ? !pwr_down : osc_tick;
    @(posedge clk);
    edge_no++;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
    last_wr = edge_no;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    step();
    step();
  endtask

  task automatic pulse_at(input int target, input string tag);
    bit early = 1'b0;
    while (edge_no < target) begin
      step();
      if (edge_no < target && wdt_rst) early = 1'b1;
    end
    chk(!early, {tag, " no early pulse"}, int'(early), 0);
    chk(wdt_rst == 1'b1, {tag, " pulse on expected edge"}, int'(wdt_rst), 1);
  endtask

  // counts enabled ticks after load_edge; pd window in absolute edge numbers
  task automatic watch_ticks(input int load_edge, input int len, input int pd_from,
                             input int pd_len, input string tag);
    int  n = 0;
    bit  early = 1'b0;
    while (edge_no < load_edge) step();
    while (n < len) begin
      pwr_down = (edge_no + 1 >= pd_from) && (edge_no + 1 < pd_from + pd_len);
      step();
      if (last_en) n++;
      if (n < len && wdt_rst) early = 1'b1;
    end
    pwr_down = 1'b0;
    chk(!early, {tag, " no early pulse"}, int'(early), 0);
    chk(wdt_rst == 1'b1, {tag, " pulse after counted ticks"}, int'(wdt_rst), 1);
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired, run hung (all requirements) actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int e0, t;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    tmo_sel = 3'd0; src_sel = 1'b1; osc_tick = 1'b0; pwr_down = 1'b0;
    step();
    // R1 reset state
    chk(wdt_rst == 1'b0, "R1 wdt_rst in reset", int'(wdt_rst), 0);
    chk(tmo_flag == 1'b0, "R1 tmo_flag in reset", int'(tmo_flag), 0);
    do_reset();
    chk(wdt_rst == 1'b0 && tmo_flag == 1'b0, "R1 outputs after release",
        int'({wdt_rst, tmo_flag}), 0);

    // vector table: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      string tag;
      int    per;
      tag = VECS[i].feed ? "R2 R5 valid feed" :
            (VECS[i].mid ? "R3 interposed write" : "R4 bad key or order");
      per = 1 << (int'(VECS[i].sel) + 5);
      tmo_sel = VECS[i].sel;
      src_sel = 1'b1;
      tick_div = 0;
      do_reset();
      wr(2'd1, 8'hA5);
      wr(2'd2, 8'h5A);
      e0 = last_wr;
      for (int k = 0; k < 8; k++) step();
      wr(VECS[i].a1, VECS[i].d1);
      if (VECS[i].mid) wr(VECS[i].ma, 8'h00);
      wr(VECS[i].a2, VECS[i].d2);
      t = (VECS[i].feed ? last_wr : e0) + 1 + per;
      pulse_at(t, tag);
    end

    // R6 R7 one-cycle pulse, self restart, sticky flag
    tmo_sel = 3'd0; src_sel = 1'b1; tick_div = 0;
    do_reset();
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'h5A);
    t = last_wr + 1 + 32;
    pulse_at(t, "R6 first expiry");
    chk(tmo_flag == 1'b1, "R7 flag set at expiry", int'(tmo_flag), 1);
    step();
    chk(wdt_rst == 1'b0, "R6 pulse lasts one cycle", int'(wdt_rst), 0);
    pulse_at(t + 32, "R6 restart full period");
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'h5A);
    step();
    chk(tmo_flag == 1'b1, "R7 flag kept over feed", int'(tmo_flag), 1);
    do_reset();
    chk(tmo_flag == 1'b0, "R7 flag cleared by reset", int'(tmo_flag), 0);

    // R8 oscillator tick source
    tmo_sel = 3'd0; src_sel = 1'b0; tick_div = 3;
    do_reset();
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'h5A);
    watch_ticks(last_wr + 1, 32, 0, 0, "R8 oscillator ticks");

    // R9 peripheral clock held during power-down
    tmo_sel = 3'd0; src_sel = 1'b1; tick_div = 0;
    do_reset();
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'h5A);
    e0 = last_wr;
    watch_ticks(e0 + 1, 32, e0 + 6, 100, "R9 held in power-down");
    chk(edge_no == e0 + 1 + 32 + 100, "R9 expiry delayed by held cycles",
        edge_no, e0 + 133);

    // R9 oscillator source ignores power-down
    tmo_sel = 3'd0; src_sel = 1'b0; tick_div = 2;
    do_reset();
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'h5A);
    e0 = last_wr;
    watch_ticks(e0 + 1, 32, e0 + 2, 1000, "R9 oscillator runs in power-down");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule